// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a 16-bit CPU and decides which exception or interrupt the CPU services next. It watches three reset causes, an illegal-opcode trap, a software interrupt, an X-maskable request, an I-maskable IRQ and a bank of peripheral request lines. It applies the CPU's I and X mask bits and drives a registered pending flag into the CPU's interrupt-recognition input.

When the CPU pulses its vector-request strobe, the block resolves priority again on that same cycle. One clock later it presents the winning 16-bit vector address. Reset vectors sit at fixed absolute addresses. Every other vector is built from a programmable base high byte and a low byte that depends on the source. If no unmasked request remains active when the strobe arrives, because the request that raised the pending flag has since gone away, the block returns a dedicated spurious vector.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The reset causes return absolute vectors and rank in this order: power-on/pin 0xFFFE, then clock-monitor 0xFFFC, then watchdog 0xFFFA. Each of them beats every other source, and the base byte has no effect on them.
- R2: The fixed non-reset sources return {base, low} with these low bytes: trap 0xF8, software interrupt 0xF6, X-maskable 0xF4, IRQ 0xF2. Their priority is trap > software > X-maskable > IRQ > any peripheral.
- R3: Peripheral line k (bit k of the request bus) returns low byte 0x82+2k. When more than one line is active, the highest k wins.
- R4: With mask_i set, IRQ and every peripheral line are ignored. With mask_x set, only the X-maskable request is ignored. Trap and software interrupt are never masked.
- R5: If no unmasked request is active on the strobe cycle, the vector is {base, 0x80}.
- R6: The base byte resets to 0xFF. On a clock edge where base_wr is high, it loads base_data. It keeps its value at all other times.
- R7: The vector is sampled on the strobe edge. vec_valid pulses for exactly one cycle after each strobe cycle, and vec_addr holds its value until the next strobe.
- R8: pending is the OR of all unmasked requests (resets, trap and software interrupt included), registered, and appears one cycle after the inputs change.
- R9: After reset, vec_addr is 0x0000 and vec_valid and pending are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_por_i | input | 1 | Power-on / pin / illegal-address / low-voltage reset cause |
| rst_clkmon_i | input | 1 | Clock-monitor reset cause |
| rst_wdog_i | input | 1 | Watchdog reset cause |
| trap_i | input | 1 | Unimplemented-opcode trap |
| swi_i | input | 1 | Software interrupt or debug vector request |
| xreq_i | input | 1 | X-maskable request |
| irq_i | input | 1 | I-maskable IRQ request |
| periph_req_i | input | 56 | Peripheral request lines |
| mask_i_i | input | 1 | CPU I mask bit |
| mask_x_i | input | 1 | CPU X mask bit |
| base_wr_i | input | 1 | Write strobe for the base byte |
| base_data_i | input | 8 | New base high byte |
| vec_req_i | input | 1 | CPU vector-request strobe |
| pending_o | output | 1 | Registered interrupt-pending flag |
| vec_addr_o | output | 16 | Registered vector address |
| vec_valid_o | output | 1 | One-cycle pulse, vec_addr_o updated |

## Verification
A wrong priority decision shows up as a wrong vector_addr on the cycle right after the strobe, so each fetch in the bench lines up sources that compete and checks which one wins. A corrupted base byte shows in the high byte of the next non-reset vector, while reset vectors must stay unchanged. A stale or mis-masked request shows as a pending flag that is wrong one cycle after the inputs change, or as a spurious vector that is missing or returned in error.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [3:0] {
    SRC_NONE,
    SRC_RST_POR,
    SRC_RST_CLK,
    SRC_RST_WDG,
    SRC_TRAP,
    SRC_SWI,
    SRC_XREQ,
    SRC_IRQ,
    SRC_PERIPH
  } src_e;

  localparam int FIXED_N = 7;

  localparam logic [15:0] VEC_RST_POR = 16'hFFFE;
  localparam logic [15:0] VEC_RST_CLK = 16'hFFFC;
  localparam logic [15:0] VEC_RST_WDG = 16'hFFFA;

  localparam logic [7:0] LOW_TRAP  = 8'hF8;
  localparam logic [7:0] LOW_SWI   = 8'hF6;
  localparam logic [7:0] LOW_XREQ  = 8'hF4;
  localparam logic [7:0] LOW_IRQ   = 8'hF2;
  localparam logic [7:0] LOW_SPUR  = 8'h80;
  localparam logic [7:0] LOW_PER0  = 8'h82;

endpackage

// File: rtl/ivc_base_reg.sv
module ivc_base_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] base_o
);

  always_ff @(posedge clk) begin
    if (rst)       base_o <= RST_VAL;
    else if (wr_i) base_o <= data_i;
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(base_o)); // R6
  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> base_o == $past(data_i)); // R6

endmodule

// File: rtl/ivc_periph_enc.sv
module ivc_periph_enc #(
  parameter int N    = 56,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o
);

  logic [N-1:0] grant;

  // highest index wins: later iterations overwrite earlier ones
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    grant = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k]) begin
        hit_o = 1'b1;
        idx_o = IDXW'(k);
        grant = '0;
        grant[k] = 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R3
  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req_i) == '0); // R3
  AST_HIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    hit_o == (req_i != '0)); // R3

endmodule

// File: rtl/ivc_fixed_sel.sv
module ivc_fixed_sel
  import ivc_pkg::*;
(
  input  logic [FIXED_N-1:0] req_i,   // [0]=por .. [6]=irq, priority order
  input  logic               per_hit_i,
  output src_e               src_o
);

  localparam src_e ORDER [FIXED_N] = '{SRC_RST_POR, SRC_RST_CLK, SRC_RST_WDG,
                                       SRC_TRAP, SRC_SWI, SRC_XREQ, SRC_IRQ};

  always_comb begin
    src_o = per_hit_i ? SRC_PERIPH : SRC_NONE;
    for (int i = FIXED_N - 1; i >= 0; i--) begin
      if (req_i[i]) src_o = ORDER[i];
    end
  end

endmodule

// File: rtl/ivc_vec_form.sv
module ivc_vec_form
  import ivc_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  src_e            src_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [7:0]      base_i,
  output logic [15:0]     vec_o
);

  logic [7:0] per_low;

  always_comb begin
    per_low = LOW_PER0 + 8'({idx_i, 1'b0});
    unique case (src_i)
      SRC_RST_POR: vec_o = VEC_RST_POR;
      SRC_RST_CLK: vec_o = VEC_RST_CLK;
      SRC_RST_WDG: vec_o = VEC_RST_WDG;
      SRC_TRAP:    vec_o = {base_i, LOW_TRAP};
      SRC_SWI:     vec_o = {base_i, LOW_SWI};
      SRC_XREQ:    vec_o = {base_i, LOW_XREQ};
      SRC_IRQ:     vec_o = {base_i, LOW_IRQ};
      SRC_PERIPH:  vec_o = {base_i, per_low};
      default:     vec_o = {base_i, LOW_SPUR};
    endcase
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_PERIPH = 56,
  parameter int BASE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rst_por_i,
  input  logic                  rst_clkmon_i,
  input  logic                  rst_wdog_i,
  input  logic                  trap_i,
  input  logic                  swi_i,
  input  logic                  xreq_i,
  input  logic                  irq_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  input  logic                  mask_i_i,
  input  logic                  mask_x_i,
  input  logic                  base_wr_i,
  input  logic [BASE_W-1:0]     base_data_i,
  input  logic                  vec_req_i,
  output logic                  pending_o,
  output logic [15:0]           vec_addr_o,
  output logic                  vec_valid_o
);

  localparam int IDXW = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  initial begin
    if (NUM_PERIPH < 1 || 8'h82 + 2 * (NUM_PERIPH - 1) > 8'hF0)
      $error("NUM_PERIPH out of vector range");
  end

  logic [BASE_W-1:0]     base_q;
  logic [NUM_PERIPH-1:0] per_req_m;
  logic [FIXED_N-1:0]    fixed_req_m;
  logic                  per_hit;
  logic [IDXW-1:0]       per_idx;
  src_e                  win_src;
  logic [15:0]           win_vec;
  logic                  pend_now;

  ivc_base_reg #(.W(BASE_W), .RST_VAL('1)) u_base (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (base_wr_i),
    .data_i (base_data_i),
    .base_o (base_q)
  );

  // masking stage
  assign per_req_m   = mask_i_i ? '0 : periph_req_i;
  assign fixed_req_m = {irq_i & ~mask_i_i, xreq_i & ~mask_x_i, swi_i, trap_i,
                        rst_wdog_i, rst_clkmon_i, rst_por_i};

  ivc_periph_enc #(.N(NUM_PERIPH), .IDXW(IDXW)) u_penc (
    .clk   (clk),
    .rst   (rst),
    .req_i (per_req_m),
    .hit_o (per_hit),
    .idx_o (per_idx)
  );

  ivc_fixed_sel u_fsel (
    .req_i     (fixed_req_m),
    .per_hit_i (per_hit),
    .src_o     (win_src)
  );

  ivc_vec_form #(.IDXW(IDXW)) u_form (
    .src_i  (win_src),
    .idx_i  (per_idx),
    .base_i (base_q[7:0]),
    .vec_o  (win_vec)
  );

  assign pend_now = (|fixed_req_m) | per_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o   <= 1'b0;
      vec_addr_o  <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      pending_o   <= pend_now;
      vec_valid_o <= vec_req_i;
      if (vec_req_i) vec_addr_o <= win_vec;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    vec_req_i |=> vec_valid_o); // R7
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !vec_req_i |=> !vec_valid_o && $stable(vec_addr_o)); // R7
  AST_SPURIOUS_LOW: assert property (@(posedge clk) disable iff (rst)
    vec_req_i && !pend_now |=> vec_addr_o[7:0] == LOW_SPUR); // R5
  AST_POR_ABS: assert property (@(posedge clk) disable iff (rst)
    vec_req_i && rst_por_i |=> vec_addr_o == VEC_RST_POR); // R1
  AST_UNMASKED_TRAP: assert property (@(posedge clk) disable iff (rst)
    vec_req_i && trap_i && !rst_por_i && !rst_clkmon_i && !rst_wdog_i
    |=> vec_addr_o[7:0] == LOW_TRAP); // R4
  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (swi_i || trap_i) |=> pending_o); // R8

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;

  localparam int NP = 56;

  logic clk = 1'b0;
  logic rst;
  logic rst_por, rst_clk, rst_wdg, trap, swi, xreq, irq;
  logic [NP-1:0] preq;
  logic msk_i, msk_x, base_wr, vreq;
  logic [7:0] base_d;
  logic pend, vvalid;
  logic [15:0] vaddr;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.NUM_PERIPH(NP)) dut_i (
    .clk(clk), .rst(rst),
    .rst_por_i(rst_por), .rst_clkmon_i(rst_clk), .rst_wdog_i(rst_wdg),
    .trap_i(trap), .swi_i(swi), .xreq_i(xreq), .irq_i(irq),
    .periph_req_i(preq), .mask_i_i(msk_i), .mask_x_i(msk_x),
    .base_wr_i(base_wr), .base_data_i(base_d), .vec_req_i(vreq),
    .pending_o(pend), .vec_addr_o(vaddr), .vec_valid_o(vvalid)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%04h exp=0x%04h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    {rst_por, rst_clk, rst_wdg, trap, swi, xreq, irq} = '0;
    preq = '0; msk_i = 0; msk_x = 0; base_wr = 0; vreq = 0;
  endtask

  task automatic fetch(input logic [15:0] exp, input string tag);
    @(negedge clk); vreq = 1;
    @(negedge clk); vreq = 0;
    chk(vvalid === 1'b1, {tag, " valid"}, 16'(vvalid), 16'h1);
    chk(vaddr === exp, tag, vaddr, exp);
  endtask

  task automatic t_reset();
    chk(vaddr === 16'h0, "R9 addr", vaddr, 16'h0);
    chk(vvalid === 1'b0, "R9 valid", 16'(vvalid), 16'h0);
    chk(pend === 1'b0, "R9 pend", 16'(pend), 16'h0);
  endtask

  task automatic t_reset_vectors();
    clear_all();
    rst_por = 1; rst_clk = 1; rst_wdg = 1; trap = 1; preq = '1;
    fetch(16'hFFFE, "R1 por wins");
    rst_por = 0; fetch(16'hFFFC, "R1 clkmon");
    rst_clk = 0; fetch(16'hFFFA, "R1 wdog");
  endtask

  task automatic t_fixed();
    clear_all();
    trap = 1; swi = 1; xreq = 1; irq = 1; preq[NP-1] = 1;
    fetch(16'hFFF8, "R2 trap");
    trap = 0; fetch(16'hFFF6, "R2 swi");
    swi = 0;  fetch(16'hFFF4, "R2 xreq");
    xreq = 0; fetch(16'hFFF2, "R2 irq");
    irq = 0;  fetch(16'hFFF0, "R2 periph last");
  endtask

  task automatic t_periph();
    clear_all();
    preq[0] = 1; fetch(16'hFF82, "R3 line0");
    preq[10] = 1; preq[3] = 1; fetch(16'hFF96, "R3 line10 wins");
    preq = '0; preq[NP-1] = 1; preq[20] = 1; fetch(16'hFFF0, "R3 top line");
  endtask

  task automatic t_masks();
    clear_all();
    msk_i = 1; irq = 1; preq[5] = 1; xreq = 1;
    fetch(16'hFFF4, "R4 I mask keeps X");
    msk_x = 1; fetch(16'hFF80, "R4 both masked");
    swi = 1; fetch(16'hFFF6, "R4 swi unmasked");
    swi = 0; trap = 1; fetch(16'hFFF8, "R4 trap unmasked");
    trap = 0; msk_i = 0; fetch(16'hFFF2, "R4 X masked irq wins");
    chk(pend === 1'b1, "R8 pend irq", 16'(pend), 16'h1);
  endtask

  task automatic t_spurious();
    clear_all();
    preq[7] = 1;
    @(negedge clk);
    chk(pend === 1'b1, "R8 pend set", 16'(pend), 16'h1);
    preq[7] = 0;
    fetch(16'hFF80, "R5 vanished");
    chk(pend === 1'b0, "R8 pend cleared", 16'(pend), 16'h0);
    msk_i = 1; irq = 1;
    @(negedge clk);
    chk(pend === 1'b0, "R8 masked no pend", 16'(pend), 16'h0);
  endtask

  task automatic t_base();
    clear_all();
    base_d = 8'h40; base_wr = 1;
    @(negedge clk); base_wr = 0; base_d = 8'h12;
    preq[0] = 1; fetch(16'h4082, "R6 periph base");
    trap = 1; fetch(16'h40F8, "R6 trap base");
    rst_wdg = 1; fetch(16'hFFFA, "R1 reset ignores base");
    rst_wdg = 0; trap = 0; preq = '0; fetch(16'h4080, "R6 spurious base");
  endtask

  task automatic t_hold();
    logic [15:0] last;
    clear_all();
    swi = 1;
    fetch(16'h40F6, "R7 fetch");
    last = vaddr;
    swi = 0; trap = 1;
    @(negedge clk);
    chk(vvalid === 1'b0, "R7 valid pulse", 16'(vvalid), 16'h0);
    chk(vaddr === last, "R7 hold", vaddr, last);
  endtask

  initial begin : wdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0x0000 exp=0x0001");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    rst = 1;
    {rst_por, rst_clk, rst_wdg, trap, swi, xreq, irq} = '0;
    preq = '0; msk_i = 0; msk_x = 0; base_wr = 0; base_d = 8'h00; vreq = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_reset_vectors();
    t_fixed();
    t_periph();
    t_masks();
    t_spurious();
    t_base();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule